// File: doc/BRIEF.md
# Prioritized interrupt level resolver

This block decides, every clock cycle, whether the core has to take an interrupt. It has two kinds of input. One is a register of software interrupt requests, which software sets with a write. The other is a vector of external interrupt lines. From both it works out the highest pending interrupt level. It also builds a bitmap of every pending source and compares the winning level with a software-owned priority-level register.

When the winning level is strictly above that register, the block does three things on one clock edge. It stores the bitmap in a summary register, stores the level in an ID register, and sends the core a trap request that lasts one cycle.

Software request bits are renumbered so that their levels start at 1. An external line uses its own bit index as its level. Any pending external line overrides the software result. While the core signals that it is busy with a trap, no new trap is raised. The ID register cannot be written; an attempt to write it is reported on an error output.

Top module: `irq_level_resolver`

## Requirements
- R1: During and after reset, `ipl_q`, `sw_req_q`, `isr_q`, `intid_q`, `trap_req` and `wr_err` are all zero.
- R2: A software-request write (`sw_wr_en`) stores `sw_wr_data & 32'h0007FFF0` in `sw_req_q`, visible after the next rising edge. Only bits 18 down to 4 are kept, which gives 15 sources.
- R3: A priority-level write (`ipl_wr_en`) stores `ipl_wr_data[4:0]` in `ipl_q`, visible after the next rising edge. Upper bits are dropped.
- R4: With no external line pending, the resolved level is (highest set bit of `sw_req_q`) − 3. This runs from 1 for bit 4 up to 15 for bit 18, and is 0 when nothing is pending.
- R5: External lines `ext_irq[31:20]` are sources; a pending line at bit i means level i. If any of them is pending, the highest such bit sets the level and replaces any software level. `ext_irq[19:0]` are ignored.
- R6: The summary is the OR of `sw_req_q` and `ext_irq[31:20]`, each placed at its own bit position.
- R7: A trap is raised only when the resolved level is nonzero and strictly greater than `ipl_q`. An equal or lower level raises no trap.
- R8: On the rising edge that sets `trap_req`, the summary is loaded into `isr_q` and the level into `intid_q`. At any other time both hold their values.
- R9: `trap_req` is never high in two consecutive cycles. No trap is raised on an edge where `trap_busy` is high.
- R10: A write attempt to the ID register (`id_wr_en`) sets `wr_err` for one cycle after the next edge and leaves `intid_q` unchanged.
- R11: On an edge where a priority-level write and a trap decision coincide, the decision uses the value of `ipl_q` from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Write strobe for the software-request register |
| sw_wr_data | input | 32 | Data for the software-request write |
| ipl_wr_en | input | 1 | Write strobe for the priority-level register |
| ipl_wr_data | input | 32 | Data for the priority-level write |
| id_wr_en | input | 1 | Write attempt to the read-only ID register |
| ext_irq | input | 32 | External interrupt lines (bits 31:20 used) |
| trap_busy | input | 1 | Core is busy with a trap; blocks new traps |
| trap_req | output | 1 | One-cycle trap request to the core |
| isr_q | output | 32 | Latched summary of pending sources |
| intid_q | output | 5 | Latched level of the taken interrupt |
| ipl_q | output | 5 | Current priority level |
| sw_req_q | output | 32 | Current software requests |
| wr_err | output | 1 | Write-to-read-only error pulse |

## Verification
Two functions can land on the same rising edge: a software write that moves `ipl_q`, and a trap decision that compares against `ipl_q`. The bench provokes this by releasing `trap_busy` in the same cycle that it writes a priority level above the pending level. The comparison must use the old level, so a trap is expected on that edge, followed by silence once the new level is in force. The bench also sweeps every single-bit and multi-bit source pattern against priority levels just below, equal to and above the resolved level. Each time it checks whether a trap occurred and what was latched. The values it expects come from the renumbering rule written out directly.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  // Mask with n ones starting at bit lo.
  function automatic logic [31:0] span_mask(input int lo, input int n);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++)
      if (i >= lo && i < lo + n) m[i] = 1'b1;
    return m;
  endfunction

  // Software source index (0-based within the group) to level.
  function automatic logic [4:0] sw_level(input logic hit, input logic [4:0] idx);
    return hit ? idx + 5'd1 : 5'd0;
  endfunction

  // External source index (0-based within the group) to level.
  function automatic logic [4:0] ext_level(input logic [4:0] idx, input int lo);
    return idx + 5'(lo);
  endfunction
endpackage

// File: rtl/irq_prio_scan.sv
module irq_prio_scan #(
  parameter int W  = 15,
  parameter int OW = 5
) (
  input  logic [W-1:0]  vec,
  output logic          hit,
  output logic [OW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        hit = 1'b1;
        idx = OW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs #(
  parameter int          DW      = 32,
  parameter int          LVL_W   = 5,
  parameter logic [31:0] SW_MASK = 32'h0007FFF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr_en,
  input  logic [DW-1:0]    sw_wr_data,
  input  logic             ipl_wr_en,
  input  logic [DW-1:0]    ipl_wr_data,
  input  logic             id_wr_en,
  output logic [DW-1:0]    sw_req_q,
  output logic [LVL_W-1:0] ipl_q,
  output logic             wr_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_req_q <= '0;
      ipl_q    <= '0;
      wr_err   <= 1'b0;
    end else begin
      if (sw_wr_en)  sw_req_q <= sw_wr_data & SW_MASK;
      if (ipl_wr_en) ipl_q    <= ipl_wr_data[LVL_W-1:0];
      wr_err <= id_wr_en;
    end
  end

  p_ipl_trim_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ipl_wr_en |=> ipl_q == $past(ipl_wr_data[LVL_W-1:0]));
  p_sw_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |=> sw_req_q == ($past(sw_wr_data) & SW_MASK));
  p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    id_wr_en |=> wr_err);
endmodule

// File: rtl/irq_trap_gate.sv
module irq_trap_gate #(
  parameter int DW    = 32,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] res_lvl,
  input  logic [DW-1:0]    summary,
  input  logic [LVL_W-1:0] ipl_q,
  input  logic             trap_busy,
  output logic             trap_req,
  output logic [DW-1:0]    isr_q,
  output logic [LVL_W-1:0] intid_q
);
  logic above_ipl;
  logic trap_fire;

  assign above_ipl = (res_lvl != '0) && (res_lvl > ipl_q);
  assign trap_fire = above_ipl && !trap_busy && !trap_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_req <= 1'b0;
      isr_q    <= '0;
      intid_q  <= '0;
    end else begin
      trap_req <= trap_fire;
      if (trap_fire) begin
        isr_q   <= summary;
        intid_q <= res_lvl;
      end
    end
  end

  p_above_ipl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> ($past(res_lvl) > $past(ipl_q)) && ($past(res_lvl) != '0));
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> !trap_req);
  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_busy |=> !trap_req);
  p_id_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |-> $stable(intid_q) && $stable(isr_q));
  p_id_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> intid_q == $past(res_lvl));
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
  import irq_lvl_pkg::*;
#(
  parameter int DW     = 32,
  parameter int LVL_W  = 5,
  parameter int SW_LO  = 4,
  parameter int SW_N   = 15,
  parameter int EXT_LO = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr_en,
  input  logic [DW-1:0]    sw_wr_data,
  input  logic             ipl_wr_en,
  input  logic [DW-1:0]    ipl_wr_data,
  input  logic             id_wr_en,
  input  logic [DW-1:0]    ext_irq,
  input  logic             trap_busy,
  output logic             trap_req,
  output logic [DW-1:0]    isr_q,
  output logic [LVL_W-1:0] intid_q,
  output logic [LVL_W-1:0] ipl_q,
  output logic [DW-1:0]    sw_req_q,
  output logic             wr_err
);
  localparam int          SW_HI    = SW_LO + SW_N - 1;
  localparam int          EXT_N    = DW - EXT_LO;
  localparam logic [31:0] SW_MASK  = span_mask(SW_LO, SW_N);
  localparam logic [31:0] EXT_MASK = span_mask(EXT_LO, EXT_N);

  logic             sw_hit, ext_hit;
  logic [LVL_W-1:0] sw_idx, ext_idx;
  logic [LVL_W-1:0] sw_lvl, ext_lvl, res_lvl;
  logic [DW-1:0]    summary;

  irq_ctl_regs #(.DW(DW), .LVL_W(LVL_W), .SW_MASK(SW_MASK[DW-1:0])) u_regs (
    .clk(clk), .rst_n(rst_n),
    .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .ipl_wr_en(ipl_wr_en), .ipl_wr_data(ipl_wr_data),
    .id_wr_en(id_wr_en),
    .sw_req_q(sw_req_q), .ipl_q(ipl_q), .wr_err(wr_err)
  );

  irq_prio_scan #(.W(SW_N), .OW(LVL_W)) u_sw_scan (
    .vec(sw_req_q[SW_HI:SW_LO]), .hit(sw_hit), .idx(sw_idx)
  );

  irq_prio_scan #(.W(EXT_N), .OW(LVL_W)) u_ext_scan (
    .vec(ext_irq[DW-1:EXT_LO]), .hit(ext_hit), .idx(ext_idx)
  );

  assign sw_lvl  = sw_level(sw_hit, sw_idx);
  assign ext_lvl = ext_level(ext_idx, EXT_LO);
  assign res_lvl = ext_hit ? ext_lvl : sw_lvl;
  assign summary = sw_req_q | (ext_irq & EXT_MASK[DW-1:0]);

  irq_trap_gate #(.DW(DW), .LVL_W(LVL_W)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .res_lvl(res_lvl), .summary(summary), .ipl_q(ipl_q),
    .trap_busy(trap_busy),
    .trap_req(trap_req), .isr_q(isr_q), .intid_q(intid_q)
  );

  p_ext_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_hit |-> res_lvl >= LVL_W'(EXT_LO));
  p_sw_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_hit && sw_hit) |-> (res_lvl >= 1) && (res_lvl <= LVL_W'(SW_N)));
  p_sw_top_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sw_hit |-> sw_req_q[SW_LO + int'(sw_idx)]);
  p_id_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (id_wr_en && !trap_req) |=> $stable(intid_q) || trap_req);
endmodule

// File: tb/irq_level_resolver_bench.sv
module irq_level_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_wr_en = 1'b0, ipl_wr_en = 1'b0, id_wr_en = 1'b0;
  logic [31:0] sw_wr_data = '0, ipl_wr_data = '0, ext_irq = '0;
  logic        trap_busy = 1'b1;
  logic        trap_req, wr_err;
  logic [31:0] isr_q, sw_req_q;
  logic [4:0]  intid_q, ipl_q;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  irq_level_resolver u_irq_level_resolver (
    .clk(clk), .rst_n(rst_n),
    .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .ipl_wr_en(ipl_wr_en), .ipl_wr_data(ipl_wr_data),
    .id_wr_en(id_wr_en), .ext_irq(ext_irq), .trap_busy(trap_busy),
    .trap_req(trap_req), .isr_q(isr_q), .intid_q(intid_q),
    .ipl_q(ipl_q), .sw_req_q(sw_req_q), .wr_err(wr_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic run_trial(input int s, input int e, input int ipl, input bit alt);
    logic [31:0] swd, ext, sum;
    logic [31:0] isr0;
    logic [4:0]  id0;
    int lvl;
    bit exp;
    string tag;
    swd = '0;
    if (s != 0) begin
      swd = 32'(1) << (s + 3);
      if (alt) swd |= ((32'(1) << (s + 3)) - 1) & ~32'hF;
    end
    ext = '0;
    if (e != 0) begin
      ext = 32'(1) << (e + 19);
      if (alt) ext |= ((32'(1) << (e + 19)) - 1) & 32'hFFF0_0000;
    end
    sum = swd | ext;
    lvl = (e != 0) ? e + 19 : s;
    exp = (lvl != 0) && (lvl > ipl);
    tag = (e != 0) ? "R5" : "R4";
    tick();
    trap_busy = 1'b1;
    sw_wr_en = 1'b1;  sw_wr_data = swd | 32'hFFF8_000F;
    ipl_wr_en = 1'b1; ipl_wr_data = 32'(ipl) | 32'hFFFF_FFE0;
    ext_irq = ext | 32'h000A_5A5A;
    tick();
    sw_wr_en = 1'b0; ipl_wr_en = 1'b0;
    chk("R2 sw mask", sw_req_q, swd);
    chk("R3 ipl trim", {27'd0, ipl_q}, 32'(ipl));
    isr0 = isr_q; id0 = intid_q;
    trap_busy = 1'b0;
    tick();
    chk("R7 trap decision", {31'd0, trap_req}, {31'd0, exp});
    if (exp) begin
      chk("R6 summary", isr_q, sum);
      chk({tag, " level"}, {27'd0, intid_q}, 32'(lvl));
    end else begin
      chk("R8 isr hold", isr_q, isr0);
      chk("R8 id hold", {27'd0, intid_q}, {27'd0, id0});
    end
    trap_busy = 1'b1;
    tick();
    chk("R9 single pulse", {31'd0, trap_req}, 32'd0);
  endtask

  initial begin
    int ipls[4];
    // R1: reset state
    repeat (3) tick();
    chk("R1 ipl", {27'd0, ipl_q}, 32'd0);
    chk("R1 sw", sw_req_q, 32'd0);
    chk("R1 isr", isr_q, 32'd0);
    chk("R1 id", {27'd0, intid_q}, 32'd0);
    chk("R1 trap", {31'd0, trap_req}, 32'd0);
    chk("R1 err", {31'd0, wr_err}, 32'd0);
    rst_n = 1'b1;
    tick();

    // R4 R5 R6 R7 R8 sweep
    for (int e = 0; e <= 12; e++) begin
      for (int s = 0; s <= 15; s++) begin
        for (int a = 0; a < 2; a++) begin
          int lvl;
          lvl = (e != 0) ? e + 19 : s;
          ipls[0] = 0;
          ipls[1] = (lvl > 0) ? lvl - 1 : 0;
          ipls[2] = lvl;
          ipls[3] = 31;
          for (int k = 0; k < 4; k++) run_trial(s, e, ipls[k], a[0]);
        end
      end
    end

    // R9: persistent request with busy low pulses every other cycle
    run_trial(7, 0, 0, 1'b0);
    trap_busy = 1'b0;
    tick(); chk("R9 persist c1", {31'd0, trap_req}, 32'd1);
    tick(); chk("R9 persist c2", {31'd0, trap_req}, 32'd0);
    tick(); chk("R9 persist c3", {31'd0, trap_req}, 32'd1);
    trap_busy = 1'b1;
    tick(); chk("R9 busy blocks", {31'd0, trap_req}, 32'd0);
    tick(); chk("R9 busy blocks 2", {31'd0, trap_req}, 32'd0);

    // R11: ipl write coinciding with trap decision uses old ipl
    run_trial(5, 0, 3, 1'b0);
    trap_busy = 1'b0;
    ipl_wr_en = 1'b1; ipl_wr_data = 32'd31;
    tick();
    ipl_wr_en = 1'b0;
    chk("R11 trap on old ipl", {31'd0, trap_req}, 32'd1);
    chk("R11 new ipl", {27'd0, ipl_q}, 32'd31);
    tick(); chk("R11 quiet after", {31'd0, trap_req}, 32'd0);
    tick(); chk("R11 quiet after 2", {31'd0, trap_req}, 32'd0);
    trap_busy = 1'b1;

    // R10: write attempt to ID register
    begin
      logic [4:0] id0;
      id0 = intid_q;
      id_wr_en = 1'b1;
      tick();
      id_wr_en = 1'b0;
      chk("R10 err pulse", {31'd0, wr_err}, 32'd1);
      chk("R10 id unchanged", {27'd0, intid_q}, {27'd0, id0});
      tick();
      chk("R10 err clears", {31'd0, wr_err}, 32'd0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule